// File: doc/BRIEF.md
# Vector Context Group Segmenter

This block walks a variable-length vector-context instruction group that arrives as a stream of 16-bit parcels. The first parcel of a group is a header. It gives the total group length, whether a vector-length parcel is present, how many parcels of register-context and predicate-context entries follow, and whether those entries are 16-bit or packed as two 8-bit entries per parcel. Every parcel after the header is sorted into its section. The section boundaries are worked out from the header while the group is being walked.

For each accepted parcel the block produces one registered result, one cycle later. The result carries a section tag, per-lane entry strobes with the entry width and the index of the entry within its section, and the implicit predicate register number for packed predicate entries. It also carries an end-of-group pulse and a malformed-length error. The block does not interpret entry contents or the trailing opcodes. A downstream decoder uses the tags and strobes to route each entry or opcode parcel.

Top module: `vbp_parser`

## Requirements
- R1: A group spans 5 + IL parcels, where IL is header bits [14:12]. `out_last` is 1 on the result for the final parcel (index 4 + IL, header = index 0) and on no other result of the group.
- R2: Each accepted parcel yields exactly one result, with `out_valid` high in the cycle after acceptance. A parcel accepted with `in_sog` high is tagged header (`out_sec` = 1). The section codes are: 0 none, 1 header, 2 vector-length, 3 register, 4 predicate, 5 opcode.
- R3: When header bit 15 is 1, parcel 1 is tagged vector-length (2). When bit 15 is 0, no parcel carries that tag.
- R4: Header bits [9:8] give N register parcels, tagged 3. They directly follow the vector-length parcel, or the header when there is none.
- R5: Header bits [11:10] give M predicate parcels, tagged 4. They directly follow the register parcels.
- R6: Every parcel after the predicate parcels, up to the group end, is tagged opcode (5). This region may be empty.
- R7: When header bit 7 is 1 (16-bit entries), each register or predicate parcel holds one entry. `ent_wide` = 1, `ent_vld` = 01, and `ent_idx` is the parcel's position within its section, starting at 0.
- R8: When header bit 7 is 0 (8-bit entries), each register or predicate parcel holds two entries. Bits [7:0] come first (lane 0) and bits [15:8] second (lane 1). `ent_wide` = 0 and `ent_idx` = 2 × the parcel's position within its section.
- R9: A packed 8-bit entry equal to 0x00 is unused. Its `ent_vld` lane bit is 0, while the other lane is still reported.
- R10: For packed predicate entries, `pred_reg` = 9 + `ent_idx`, which is the register number for lane 0; lane 1 uses the next number. On every other result `pred_reg` is 0.
- R11: When 1 + (bit 15) + N + M exceeds 5 + IL, `out_err` is 1 on every result of that group. All parcels after the header are tagged none with no entry strobes, and `out_last` still marks the final parcel.
- R12: A parcel accepted with `in_sog` high restarts the walk as a new header, even in the middle of a group.
- R13: A parcel accepted outside any group is tagged none, with no strobes, no `out_last` and no `out_err`.
- R14: `in_ready` is 1 whenever reset is low. During reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Parcel present |
| in_ready | output | 1 | Parcel accepted when high together with in_valid |
| in_data | input | 16 | Parcel contents |
| in_sog | input | 1 | Parcel is the header of a new group |
| out_valid | output | 1 | Result for the parcel accepted in the previous cycle |
| out_sec | output | 3 | Section tag (0 none, 1 header, 2 vector-length, 3 register, 4 predicate, 5 opcode) |
| out_last | output | 1 | Final parcel of the group |
| out_err | output | 1 | Group length too short for its entries |
| ent_vld | output | 2 | Entry strobe per lane (lane 0 = low byte or whole parcel) |
| ent_wide | output | 1 | Entries are 16-bit |
| ent_idx | output | 3 | Index of the lane-0 entry within its section |
| pred_reg | output | 5 | Implicit predicate register number for lane 0 of packed predicate entries |

## Verification
The segmenter is exercised with several header shapes:
- A 16-bit-entry group with a vector-length parcel and a non-empty opcode region.
- A packed group that fills its length exactly, so the group ends on a predicate parcel. It includes zero bytes in both lanes.
- A group that is too short, which separates the error path from normal tagging.
- A long group fed with idle gaps between parcels.

Back-to-back groups, a header arriving mid-group, and stray parcels outside any group show that the walk state is cleared and restarted correctly rather than carried over.

// File: rtl/vbp_pkg.sv
package vbp_pkg;
    localparam int PARCEL_W     = 16;
    localparam int BYTE_W       = 8;
    localparam int LANES        = PARCEL_W / BYTE_W;
    localparam int POS_W        = 4;
    localparam int IDX_W        = 3;
    localparam int REG_W        = 5;
    localparam int BASE_PARCELS = 5;

    typedef enum logic [2:0] {
        SEC_NONE = 3'd0,
        SEC_HDR  = 3'd1,
        SEC_VLB  = 3'd2,
        SEC_REG  = 3'd3,
        SEC_PRED = 3'd4,
        SEC_OPC  = 3'd5
    } sec_e;

    typedef struct packed {
        logic             wide;
        logic [POS_W-1:0] len;
        logic [POS_W-1:0] b_reg;
        logic [POS_W-1:0] b_pred;
        logic [POS_W-1:0] b_opc;
        logic             overrun;
    } hdr_t;

    typedef struct packed {
        sec_e             sec;
        logic [POS_W-1:0] off;
        logic             last;
        logic             err;
        logic             wide;
    } beat_t;

    typedef struct packed {
        logic [LANES-1:0] vld;
        logic             wide;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] preg;
    } ent_t;

    function automatic logic [POS_W-1:0] ext2(input logic [1:0] v);
        return {{(POS_W-2){1'b0}}, v};
    endfunction
endpackage

// File: rtl/vbp_hdr_decode.sv
module vbp_hdr_decode
    import vbp_pkg::*;
(
    input  logic [PARCEL_W-1:0] word,
    output hdr_t                hdr
);
    logic unused_low;
    assign unused_low = ^word[6:0];

    logic [POS_W-1:0] vl_cnt;

    always_comb begin
        vl_cnt      = {{(POS_W-1){1'b0}}, word[15]};
        hdr.wide    = word[7];
        hdr.len     = POS_W'(BASE_PARCELS) + {1'b0, word[14:12]};
        hdr.b_reg   = POS_W'(1) + vl_cnt;
        hdr.b_pred  = hdr.b_reg + ext2(word[9:8]);
        hdr.b_opc   = hdr.b_pred + ext2(word[11:10]);
        hdr.overrun = hdr.b_opc > hdr.len;
    end
endmodule

// File: rtl/vbp_walker.sv
module vbp_walker
    import vbp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  logic  sog,
    input  hdr_t  hdr_in,
    output beat_t beat
);
    logic             in_grp;
    logic [POS_W-1:0] pos;
    hdr_t             hdr_q;

    always_comb begin
        beat = '0;
        if (sog) begin
            beat.sec  = SEC_HDR;
            beat.err  = hdr_in.overrun;
            beat.wide = hdr_in.wide;
        end else if (in_grp) begin
            beat.last = (pos == hdr_q.len - POS_W'(1));
            beat.err  = hdr_q.overrun;
            beat.wide = hdr_q.wide;
            if (hdr_q.overrun) begin
                beat.sec = SEC_NONE;
            end else if (pos < hdr_q.b_reg) begin
                beat.sec = SEC_VLB;
            end else if (pos < hdr_q.b_pred) begin
                beat.sec = SEC_REG;
                beat.off = pos - hdr_q.b_reg;
            end else if (pos < hdr_q.b_opc) begin
                beat.sec = SEC_PRED;
                beat.off = pos - hdr_q.b_pred;
            end else begin
                beat.sec = SEC_OPC;
                beat.off = pos - hdr_q.b_opc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_grp <= 1'b0;
            pos    <= '0;
            hdr_q  <= '0;
        end else if (fire) begin
            if (sog) begin
                in_grp <= 1'b1;
                pos    <= POS_W'(1);
                hdr_q  <= hdr_in;
            end else if (in_grp) begin
                pos <= pos + POS_W'(1);
                if (beat.last) in_grp <= 1'b0;
            end
        end
    end

    // R1: the walk position never reaches the group length
    a_r1_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        in_grp |-> (pos < hdr_q.len));

    // R12: a header always restarts the walk at parcel 1
    a_r12_restart: assert property (@(posedge clk) disable iff (rst)
        (fire && sog) |=> (in_grp && pos == POS_W'(1)));
endmodule

// File: rtl/vbp_entry_gen.sv
module vbp_entry_gen
    import vbp_pkg::*;
#(
    parameter int PRED_FIRST = 9
) (
    input  beat_t               beat,
    input  logic [PARCEL_W-1:0] data,
    output ent_t                ent
);
    logic [LANES-1:0] byte_used;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_used[g] = |data[g*BYTE_W +: BYTE_W];
    end

    logic is_entry;
    assign is_entry = (beat.sec == SEC_REG) || (beat.sec == SEC_PRED);

    always_comb begin
        ent = '0;
        if (is_entry) begin
            ent.wide = beat.wide;
            if (beat.wide) begin
                ent.vld = LANES'(1);
                ent.idx = beat.off[IDX_W-1:0];
            end else begin
                ent.vld = byte_used;
                ent.idx = {beat.off[IDX_W-2:0], 1'b0};
                if (beat.sec == SEC_PRED)
                    ent.preg = REG_W'(PRED_FIRST) + REG_W'(ent.idx);
            end
        end
    end
endmodule

// File: rtl/vbp_parser.sv
module vbp_parser
    import vbp_pkg::*;
#(
    parameter int PRED_FIRST = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    input  logic        in_sog,
    output logic        out_valid,
    output logic [2:0]  out_sec,
    output logic        out_last,
    output logic        out_err,
    output logic [1:0]  ent_vld,
    output logic        ent_wide,
    output logic [2:0]  ent_idx,
    output logic [4:0]  pred_reg
);
    logic  fire;
    hdr_t  hdr_dec;
    beat_t beat;
    ent_t  ent;

    assign in_ready = !rst;
    assign fire     = in_valid && in_ready;

    vbp_hdr_decode u_dec (
        .word (in_data),
        .hdr  (hdr_dec)
    );

    vbp_walker u_walk (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .sog    (in_sog),
        .hdr_in (hdr_dec),
        .beat   (beat)
    );

    vbp_entry_gen #(.PRED_FIRST(PRED_FIRST)) u_ent (
        .beat (beat),
        .data (in_data),
        .ent  (ent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sec   <= SEC_NONE;
            out_last  <= 1'b0;
            out_err   <= 1'b0;
            ent_vld   <= '0;
            ent_wide  <= 1'b0;
            ent_idx   <= '0;
            pred_reg  <= '0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_sec  <= beat.sec;
                out_last <= beat.last;
                out_err  <= beat.err;
                ent_vld  <= ent.vld;
                ent_wide <= ent.wide;
                ent_idx  <= ent.idx;
                pred_reg <= ent.preg;
            end
        end
    end

    // R2: one result per accepted parcel, one cycle later
    a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
        fire |=> out_valid);

    // R2: a header parcel is tagged header
    a_r2_hdr_tag: assert property (@(posedge clk) disable iff (rst)
        (fire && in_sog) |=> (out_sec == SEC_HDR));

    // R9: packed lane strobes follow the nonzero bytes of the parcel
    a_r9_zero_byte: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ent_wide && (out_sec == SEC_REG || out_sec == SEC_PRED))
        |-> (ent_vld == {$past(in_data[15:8]) != 8'h00, $past(in_data[7:0]) != 8'h00}));

    // R10: predicate register only on packed predicate results
    a_r10_pred_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_sec == SEC_PRED && !ent_wide)) |-> (pred_reg == '0));

    // R11: an errored group tags nothing after its header
    a_r11_err_silent: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err && out_sec != SEC_HDR) |-> (out_sec == SEC_NONE && ent_vld == '0));

    // R13: untagged parcels outside a group carry nothing
    a_r13_stray_quiet: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sec == SEC_NONE && !out_err) |-> (ent_vld == '0 && !out_last));
endmodule

// File: tb/vbp_parser_test.sv
module vbp_parser_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        in_sog = 1'b0;
    logic        out_valid;
    logic [2:0]  out_sec;
    logic        out_last;
    logic        out_err;
    logic [1:0]  ent_vld;
    logic        ent_wide;
    logic [2:0]  ent_idx;
    logic [4:0]  pred_reg;

    always #2 clk = ~clk;

    vbp_parser uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sog(in_sog), .out_valid(out_valid),
        .out_sec(out_sec), .out_last(out_last), .out_err(out_err),
        .ent_vld(ent_vld), .ent_wide(ent_wide), .ent_idx(ent_idx),
        .pred_reg(pred_reg)
    );

    typedef struct {
        int    sec;
        int    last;
        int    err;
        int    vld;
        int    wide;
        int    idx;
        int    preg;
        string lbl;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string lbl_force = "";

    int m_in = 0, m_pos = 0, m_len = 0, m_err = 0;
    int m_vl = 0, m_rc = 0, m_pc = 0, m_wide = 0;

    task automatic chk(input string req, input string what, input int act, input int expv);
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic fill_entry(inout exp_t e, input logic [15:0] d, input int k, input bit pred);
        if (m_wide != 0) begin
            e.vld = 1; e.wide = 1; e.idx = k; e.lbl = "R7";
        end else begin
            e.vld  = ((d[15:8] != 0) ? 2 : 0) + ((d[7:0] != 0) ? 1 : 0);
            e.idx  = 2 * k;
            e.lbl  = (e.vld != 3) ? "R9" : "R8";
            if (pred) begin
                e.preg = 9 + 2 * k;
                e.lbl  = "R10";
            end
        end
    endtask

    task automatic model(input logic [15:0] d, input logic s);
        exp_t e;
        e = '{0, 0, 0, 0, 0, 0, 0, "R13"};
        if (s) begin
            m_vl = d[15]; m_wide = d[7]; m_rc = d[9:8]; m_pc = d[11:10];
            m_len = 5 + d[14:12];
            m_err = ((1 + m_vl + m_rc + m_pc) > m_len) ? 1 : 0;
            m_in = 1; m_pos = 1;
            e.sec = 1; e.err = m_err; e.lbl = "R2";
        end else if (m_in != 0) begin
            int p;
            p = m_pos;
            e.last = (p == m_len - 1) ? 1 : 0;
            e.err = m_err;
            if (m_err != 0) begin
                e.sec = 0; e.lbl = "R11";
            end else if (m_vl != 0 && p == 1) begin
                e.sec = 2; e.lbl = "R3";
            end else if (p < 1 + m_vl + m_rc) begin
                e.sec = 3; e.lbl = "R4";
                fill_entry(e, d, p - 1 - m_vl, 1'b0);
            end else if (p < 1 + m_vl + m_rc + m_pc) begin
                e.sec = 4; e.lbl = "R5";
                fill_entry(e, d, p - 1 - m_vl - m_rc, 1'b1);
            end else begin
                e.sec = 5; e.lbl = "R6";
            end
            if (e.last != 0 && m_err == 0 && e.sec == 5) e.lbl = "R1";
            m_pos++;
            if (e.last != 0) m_in = 0;
        end
        if (lbl_force != "") e.lbl = lbl_force;
        q.push_back(e);
    endtask

    task automatic put(input logic [15:0] d, input logic s);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sog = s;
        model(d, s);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sog = 1'b0;
        end
    endtask

    // monitor: pops the expected result for every produced result
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R2 unexpected result: actual tag %0d expected none", out_sec);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.lbl, "out_sec",  int'(out_sec),  e.sec);
                    chk(e.lbl, "out_last", int'(out_last), e.last);
                    chk(e.lbl, "out_err",  int'(out_err),  e.err);
                    chk(e.lbl, "ent_vld",  int'(ent_vld),  e.vld);
                    chk(e.lbl, "ent_wide", int'(ent_wide), e.wide);
                    chk(e.lbl, "ent_idx",  int'(ent_idx),  e.idx);
                    chk(e.lbl, "pred_reg", int'(pred_reg), e.preg);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; chk("R14", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        checks++; chk("R14", "in_ready", int'(in_ready), 1);
        checks++; chk("R14", "out_valid idle", int'(out_valid), 0);

        // stray parcel outside any group (R13)
        put(16'h1234, 1'b0);
        idle(1);

        // 16-bit entries, VL parcel, 2 reg, 1 pred, IL=3
        put(16'hB680, 1'b1);
        put(16'h0011, 1'b0);
        put(16'h0000, 1'b0);
        put(16'hABCD, 1'b0);
        put(16'h7777, 1'b0);
        put(16'h0013, 1'b0);
        put(16'h0023, 1'b0);
        put(16'h0033, 1'b0);
        // packed entries, 3 reg, 3 pred, IL=2, group ends on a predicate parcel
        put(16'h2F00, 1'b1);
        put(16'h1234, 1'b0);
        put(16'h0056, 1'b0);
        put(16'h0000, 1'b0);
        put(16'h8100, 1'b0);
        put(16'h0203, 1'b0);
        put(16'h4400, 1'b0);
        idle(2);

        // overrun group (R11): VL + 3 + 3 in length 5
        put(16'h8F80, 1'b1);
        for (int i = 0; i < 4; i++) put(16'h5555, 1'b0);
        // stray parcel after the group ended (R13)
        put(16'h00FF, 1'b0);
        idle(1);

        // restart mid-group (R12)
        put(16'hB680, 1'b1);
        put(16'h0001, 1'b0);
        lbl_force = "R12";
        put(16'h0080, 1'b1);
        lbl_force = "";
        for (int i = 0; i < 4; i++) put(16'h0101, 1'b0);

        // long group with idle gaps: IL=7, 1 reg, no VL
        put(16'h7180, 1'b1);
        for (int i = 0; i < 11; i++) begin
            put(16'h0200 + 16'(i), 1'b0);
            if (i % 3 == 0) idle(2);
        end
        // packed predicate-only group, opcode region follows
        put(16'h1800, 1'b1);
        put(16'h0009, 1'b0);
        put(16'h0700, 1'b0);
        for (int i = 0; i < 4; i++) put(16'h1111, 1'b0);
        idle(4);

        checks++;
        chk("R2", "pending results", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule